// File: doc/BRIEF.md
# USB Host Port Control and Status Register

This block is the software-visible control and status word for one downstream USB host port. A simple single-word register bus writes and reads the whole 32-bit word. The same word mixes several kinds of field:

- read-only fields that mirror the live port condition: the attached device speed, the two data-line levels, the connection and the enable state;
- read-write controls that drive the port: power, the reset request, the resume request and the test-mode code;
- a write-1-to-set suspend bit, which the hardware clears again by itself;
- two write-1-to-clear event flags, which together raise one port interrupt.

A port state machine outside this block supplies the live inputs and the event pulses. It consumes the power, reset, resume, suspend, SOF-enable and test-code outputs. Suspend does one thing only: it gates SOF transmission.

Suspend is tracked by a two-state machine, `SUSP_ACTIVE` and `SUSP_HALTED`. The transition `T_ENTER` goes from active to halted when software writes 1 to the suspend bit and no clearing cause is present in that cycle. The transition `T_WAKE` goes from halted to active on any of these causes:

- a remote-wakeup pulse;
- a write that takes the reset bit from 0 to 1;
- a write that takes the resume bit from 0 to 1.

In every other case the machine stays in its current state.

Top module: `usb_hport_csr`

## Requirements
- R1: After an active-low synchronous reset, the word reads as 0 apart from the live read-only fields. Power, reset, resume, suspend and the test code are all 0, `sof_enable` is 1 and `port_irq` is 0.
- R2: The read-only fields follow their inputs. Speed is at bits 18:17 (01 full speed, 10 low speed, 00 and 11 reserved). D+ is at bit 10, D− at bit 11, live connection at bit 0 and port enabled at bit 2. Writes to these bits have no effect.
- R3: The test code at bits 16:13 is read-write. Any 4-bit value, reserved codes included, is stored, read back and driven on `test_code`. Codes: 0 off, 1 J, 2 K, 3 SE0_NAK, 4 Packet, 5 Force_Enable.
- R4: Power (bit 12), reset (bit 8) and resume (bit 6) are read-write and drive `port_power`, `port_reset` and `port_resume`. The reset bit stays 1 until software writes 0 to it.
- R5: Suspend (bit 7) is write-1-to-set. Writing 0 to it leaves it unchanged. A read returns the current suspend state, and `sof_enable` is its inverse.
- R6: Suspend is cleared by a `wakeup_evt` pulse, by a write that takes the reset bit from 0 to 1, and by a write that takes the resume bit from 0 to 1. A clear cause in the same cycle as a suspend-set write wins. A write that keeps an already-set reset bit at 1 is not a clear cause.
- R7: The connect-detected flag (bit 1) is set by `connect_evt`. The enable-change flag (bit 3) is set by `enable_chg_evt`. Writing 1 to a flag clears it, and writing 0 to it has no effect.
- R8: An event pulse in the same cycle as a write-1 clear of its flag leaves the flag set.
- R9: `port_irq` is 1 exactly when at least one of the two flags is set.
- R10: Bits 31:19, 9, 5 and 4 read as 0 whatever is written. A read of any other address returns 0, and a write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| hw_speed | input | 2 | Attached device speed code |
| hw_dp | input | 1 | D+ line level |
| hw_dm | input | 1 | D− line level |
| hw_connected | input | 1 | Live connection state |
| hw_enabled | input | 1 | Port enabled state |
| connect_evt | input | 1 | Connection detected pulse |
| enable_chg_evt | input | 1 | Enable state changed pulse |
| wakeup_evt | input | 1 | Remote wakeup detected pulse |
| port_power | output | 1 | Power request |
| port_reset | output | 1 | Reset request |
| port_resume | output | 1 | Resume request |
| port_suspend | output | 1 | Port suspended |
| sof_enable | output | 1 | SOF transmission allowed |
| test_code | output | 4 | Test-mode code |
| port_irq | output | 1 | Combined port interrupt |

## Verification
The read-only fields are swept over all 64 combinations of speed, line levels, connection and enable. This separates each field's bit position from its neighbours. The test code is written and read back for all 16 values, which shows that reserved codes are stored rather than filtered. Every suspend set and clear cause is applied, alone and combined with a set write in the same cycle, and so is a reset write that does not rise. This tells the clear-wins ordering apart from set-wins and from a level-sensitive clear. The flags are driven with event only, clear only, write-0 and event-plus-clear patterns, with the interrupt checked after each step. Writes of all ones and accesses to a foreign address show that reserved bits and other addresses change nothing.

// File: rtl/usb_hport_pkg.sv
package usb_hport_pkg;
    localparam int WORD_W   = 32;
    localparam int CONN_B   = 0;
    localparam int CDET_B   = 1;
    localparam int EN_B     = 2;
    localparam int ECHG_B   = 3;
    localparam int RES_B    = 6;
    localparam int SUSP_B   = 7;
    localparam int RST_B    = 8;
    localparam int DP_B     = 10;
    localparam int DM_B     = 11;
    localparam int PWR_B    = 12;
    localparam int TEST_LO  = 13;
    localparam int TEST_W   = 4;
    localparam int SPD_LO   = 17;
    localparam int SPD_W    = 2;
    localparam int NUM_FLAG = 2;

    typedef enum logic {
        SUSP_ACTIVE = 1'b0,
        SUSP_HALTED = 1'b1
    } susp_state_e;

    function automatic int flag_pos(input int idx);
        return (idx == 0) ? CDET_B : ECHG_B;
    endfunction
endpackage

// File: rtl/usb_hport_w1c_flag.sv
module usb_hport_w1c_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_wr,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (set_evt) flag_q <= 1'b1;
        else if (clr_wr)  flag_q <= 1'b0;
    end
endmodule

// File: rtl/usb_hport_susp_fsm.sv
module usb_hport_susp_fsm
    import usb_hport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic suspended
);
    susp_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SUSP_ACTIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SUSP_ACTIVE: if (set_req && !clr_req) state_d = SUSP_HALTED; // T_ENTER
            SUSP_HALTED: if (clr_req)             state_d = SUSP_ACTIVE; // T_WAKE
            default:                              state_d = SUSP_ACTIVE;
        endcase
    end

    always_comb begin
        suspended = (state_q == SUSP_HALTED);
    end
endmodule

// File: rtl/usb_hport_rdmux.sv
module usb_hport_rdmux
    import usb_hport_pkg::*;
(
    input  logic [SPD_W-1:0]  speed,
    input  logic [TEST_W-1:0] test,
    input  logic              pwr,
    input  logic              dp,
    input  logic              dm,
    input  logic              rst,
    input  logic              susp,
    input  logic              res,
    input  logic              en,
    input  logic              conn,
    input  logic [NUM_FLAG-1:0] flags,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        word = '0;
        word[SPD_LO +: SPD_W]   = speed;
        word[TEST_LO +: TEST_W] = test;
        word[PWR_B]  = pwr;
        word[DM_B]   = dm;
        word[DP_B]   = dp;
        word[RST_B]  = rst;
        word[SUSP_B] = susp;
        word[RES_B]  = res;
        word[EN_B]   = en;
        word[CONN_B] = conn;
        for (int i = 0; i < NUM_FLAG; i++) word[flag_pos(i)] = flags[i];
    end
endmodule

// File: rtl/usb_hport_csr.sv
module usb_hport_csr
    import usb_hport_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [1:0]        hw_speed,
    input  logic              hw_dp,
    input  logic              hw_dm,
    input  logic              hw_connected,
    input  logic              hw_enabled,
    input  logic              connect_evt,
    input  logic              enable_chg_evt,
    input  logic              wakeup_evt,
    output logic              port_power,
    output logic              port_reset,
    output logic              port_resume,
    output logic              port_suspend,
    output logic              sof_enable,
    output logic [3:0]        test_code,
    output logic              port_irq
);
    logic                sel;
    logic                wr_hit;
    logic                susp_set;
    logic                susp_clr;
    logic [NUM_FLAG-1:0] flag_evt;
    logic [NUM_FLAG-1:0] sts_q;
    logic [WORD_W-1:0]   word;

    assign sel    = (bus_addr == REG_ADDR);
    assign wr_hit = bus_we && sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_code   <= '0;
            port_power  <= 1'b0;
            port_reset  <= 1'b0;
            port_resume <= 1'b0;
        end else if (wr_hit) begin
            test_code   <= bus_wdata[TEST_LO +: TEST_W];
            port_power  <= bus_wdata[PWR_B];
            port_reset  <= bus_wdata[RST_B];
            port_resume <= bus_wdata[RES_B];
        end
    end

    assign susp_set = wr_hit && bus_wdata[SUSP_B];
    assign susp_clr = wakeup_evt
                   || (wr_hit && bus_wdata[RST_B] && !port_reset)
                   || (wr_hit && bus_wdata[RES_B] && !port_resume);

    usb_hport_susp_fsm u_susp (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_req   (susp_set),
        .clr_req   (susp_clr),
        .suspended (port_suspend)
    );

    assign sof_enable  = !port_suspend;
    assign flag_evt[0] = connect_evt;
    assign flag_evt[1] = enable_chg_evt;

    for (genvar i = 0; i < NUM_FLAG; i++) begin : g_flag
        localparam int POS = flag_pos(i);
        usb_hport_w1c_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (flag_evt[i]),
            .clr_wr  (wr_hit && bus_wdata[POS]),
            .flag_q  (sts_q[i])
        );
    end

    assign port_irq = |sts_q;

    usb_hport_rdmux u_rd (
        .speed (hw_speed),
        .test  (test_code),
        .pwr   (port_power),
        .dp    (hw_dp),
        .dm    (hw_dm),
        .rst   (port_reset),
        .susp  (port_suspend),
        .res   (port_resume),
        .en    (hw_enabled),
        .conn  (hw_connected),
        .flags (sts_q),
        .word  (word)
    );

    assign bus_rdata = sel ? word : '0;
endmodule

// File: rtl/usb_hport_csr_chk.sv
module usb_hport_csr_chk #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h40
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              connect_evt,
    input logic              enable_chg_evt,
    input logic              wakeup_evt,
    input logic              port_reset,
    input logic              port_resume,
    input logic              port_suspend,
    input logic              port_irq,
    input logic [1:0]        sts_q
);
    logic hit;
    assign hit = bus_we && (bus_addr == REG_ADDR);

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_irq) |-> $past(connect_evt || enable_chg_evt));

    assert_wake_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wakeup_evt |=> !port_suspend);

    assert_suspend_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(port_suspend) |-> $past(wakeup_evt
            || (hit && bus_wdata[8] && !port_reset)
            || (hit && bus_wdata[6] && !port_resume)));

    assert_suspend_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_suspend) |-> $past(hit && bus_wdata[7]));

    assert_conn_evt_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        connect_evt |=> sts_q[0]);

    assert_chg_evt_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        enable_chg_evt |=> sts_q[1]);

    assert_reset_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(port_reset));

    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[31:19] == 13'd0) && !bus_rdata[9] && (bus_rdata[5:4] == 2'b00));
endmodule

bind usb_hport_csr usb_hport_csr_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_addr       (bus_addr),
    .bus_we         (bus_we),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .connect_evt    (connect_evt),
    .enable_chg_evt (enable_chg_evt),
    .wakeup_evt     (wakeup_evt),
    .port_reset     (port_reset),
    .port_resume    (port_resume),
    .port_suspend   (port_suspend),
    .port_irq       (port_irq),
    .sts_q          (sts_q)
);

// File: tb/tb_usb_hport_csr.sv
`timescale 1ns/1ps
module tb_usb_hport_csr;
    localparam logic [7:0] RA = 8'h40;
    localparam logic [31:0] RO_MASK = 32'h0006_0C05;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] bus_addr = RA;
    logic bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0] hw_speed = 2'b00;
    logic hw_dp = 0, hw_dm = 0, hw_connected = 0, hw_enabled = 0;
    logic connect_evt = 0, enable_chg_evt = 0, wakeup_evt = 0;
    logic port_power, port_reset, port_resume, port_suspend, sof_enable, port_irq;
    logic [3:0] test_code;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    usb_hport_csr dut (.*);

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d, input logic [7:0] a = RA);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = RA; bus_wdata = '0;
        #1;
    endtask

    task automatic step;
        @(negedge clk); #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check(bus_rdata, 32'h0, "R1 word");
        check({port_power, port_reset, port_resume, port_suspend, sof_enable, port_irq, test_code},
              {5'b00001, 1'b0, 4'h0}, "R1 outputs");
        @(negedge clk); rst_n = 1'b1; #1;
        check(bus_rdata, 32'h0, "R1 word after release");

        // R2 sweep of live read-only fields
        for (int v = 0; v < 64; v++) begin
            @(negedge clk);
            {hw_speed, hw_dp, hw_dm, hw_connected, hw_enabled} = 6'(v);
            #1;
            check(bus_rdata & RO_MASK,
                  (32'(v[5:4]) << 17) | (32'(v[2]) << 11) | (32'(v[3]) << 10)
                  | (32'(v[0]) << 2) | 32'(v[1]), "R2 live fields");
        end
        {hw_speed, hw_dp, hw_dm, hw_connected, hw_enabled} = 6'b0;
        wr(RO_MASK);
        check(bus_rdata, 32'h0, "R2 write to read-only ignored");

        // R3 every test code
        for (int c = 0; c < 16; c++) begin
            wr(32'(c) << 13);
            check(bus_rdata, 32'(c) << 13, "R3 readback");
            check(32'(test_code), 32'(c), "R3 test_code");
        end
        wr(32'h0);

        // R4 power / reset / resume
        wr(32'h1000);
        check({port_power, port_reset, port_resume}, 3'b100, "R4 power");
        wr(32'h1100);
        repeat (20) step;
        check({port_power, port_reset, bus_rdata[8]}, 3'b111, "R4 reset held");
        wr(32'h0040);
        check({port_power, port_reset, port_resume, bus_rdata[6]}, 4'b0011, "R4 resume");
        wr(32'h0);

        // R5 suspend write-1-to-set
        wr(32'h0080);
        check({port_suspend, sof_enable, bus_rdata[7]}, 3'b101, "R5 set");
        wr(32'h0);
        check({port_suspend, sof_enable}, 2'b10, "R5 write 0 ignored");

        // R6 clear causes
        @(negedge clk); wakeup_evt = 1; @(negedge clk); wakeup_evt = 0; #1;
        check({port_suspend, sof_enable}, 2'b01, "R6 wakeup clears");
        wr(32'h0080);
        wr(32'h0100);
        check({port_suspend, port_reset}, 2'b01, "R6 reset rise clears");
        wr(32'h0180);
        check({port_suspend, port_reset}, 2'b11, "R6 held reset not a clear");
        wr(32'h0);
        wr(32'h0040);
        check(32'(port_suspend), 32'h0, "R6 resume rise clears");
        wr(32'h0);
        wr(32'h0180);
        check({port_suspend, port_reset}, 2'b01, "R6 clear wins over set");
        wr(32'h0);
        wr(32'h00C0);
        check({port_suspend, port_resume}, 2'b01, "R6 resume wins over set");
        wr(32'h0);
        wr(32'h0080);
        @(negedge clk); bus_we = 1; bus_wdata = 32'h80; wakeup_evt = 1;
        @(negedge clk); bus_we = 0; bus_wdata = 0; wakeup_evt = 0; #1;
        check(32'(port_suspend), 32'h0, "R6 wakeup wins over set");

        // R7 and R9 flags and interrupt
        check(32'(port_irq), 32'h0, "R9 idle");
        @(negedge clk); connect_evt = 1; @(negedge clk); connect_evt = 0; #1;
        check(bus_rdata & 32'hA, 32'h2, "R7 connect flag");
        check(32'(port_irq), 32'h1, "R9 irq from connect");
        @(negedge clk); enable_chg_evt = 1; @(negedge clk); enable_chg_evt = 0; #1;
        check(bus_rdata & 32'hA, 32'hA, "R7 both flags");
        wr(32'h0);
        check(bus_rdata & 32'hA, 32'hA, "R7 write 0 ignored");
        wr(32'h2);
        check({bus_rdata[3:0], 3'b0, port_irq}, {4'h8, 4'h1}, "R7/R9 clear connect");
        wr(32'h8);
        check({bus_rdata[3:0], 3'b0, port_irq}, 8'h00, "R7/R9 clear change");

        // R8 event vs clear in same cycle
        @(negedge clk); connect_evt = 1; @(negedge clk); connect_evt = 0;
        @(negedge clk); bus_we = 1; bus_wdata = 32'hA; connect_evt = 1; enable_chg_evt = 1;
        @(negedge clk); bus_we = 0; bus_wdata = 0; connect_evt = 0; enable_chg_evt = 0; #1;
        check(bus_rdata & 32'hA, 32'hA, "R8 event wins");
        wr(32'hA);
        check(32'(port_irq), 32'h0, "R8 cleared afterwards");

        // R10 reserved bits and foreign address
        wr(32'hFFF8_0230);
        check(bus_rdata, 32'h0, "R10 reserved ignored");
        wr(32'h0001_F1C0, 8'h44);
        check(bus_rdata, 32'h0, "R10 foreign write ignored");
        wr(32'h1000);
        @(negedge clk); bus_addr = 8'h00; #1;
        check(bus_rdata, 32'h0, "R10 foreign read zero");
        bus_addr = RA; #1;
        check(bus_rdata, 32'h1000, "R10 own read");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule